// File: doc/BRIEF.md
# Open-Drain Port Register Bank

This block is the register file that sits behind an already decoded serial command stream. Each command arrives as a one-cycle valid strobe with a read/write flag, a 7-bit address and a data byte. The bank holds one byte for each of ten open-drain ports and one general-purpose scratch byte. Bit 0 of each port byte drives an active-low pull-down enable. When that enable is released, the pin floats so that it can be used as an input.

A write to one of a small set of group addresses loads the same byte into several port registers in a single command. Ports are grouped in fours by index, and the last group may be partial. Two read-only addresses return the synchronised pin levels packed into bytes. A read of any address that holds no data returns zero. This includes the no-op address and the reserved address, and writes to those addresses change nothing. Read data is a combinational function of the address. Writes are registered.

Top module: `odx_bank`

## Requirements
- R1: During and after a synchronous reset, every port register holds 0xFF, the scratch byte holds 0x00 and all ten `pull_n` bits are 1.
- R2: A write to address 0x00+i (i = 0..9) stores all eight data bits in port register i, and a read of that address returns them unchanged.
- R3: `pull_n[i]` equals bit 0 of port register i. A value of 0 pulls the pin low and a value of 1 releases it.
- R4: A write to 0x0A loads every port register with the data byte.
- R5: A write to 0x0B loads ports 0–3, 0x0C loads ports 4–7 and 0x0D loads ports 8–9. Ports outside the addressed group keep their values.
- R6: A read of 0x0A or 0x0B returns port register 0, a read of 0x0C returns port register 4 and a read of 0x0D returns port register 8.
- R7: A read of 0x0E returns the pin levels of ports 7..0 in bits 7..0. A read of 0x0F returns ports 9 and 8 in bits 1 and 0, with the other bits 0. A write to either address changes no register.
- R8: A pin level reaches the 0x0E/0x0F read data after two rising clock edges, and not after one.
- R9: Address 0x13 is a read/write scratch byte.
- R10: A write to 0x20 (no-op), 0x7D (reserved) or any unmapped address such as 0x15 changes no register. A read of any of these addresses returns 0x00.
- R11: A write is visible on the outputs in the cycle after its strobe. A strobe with the read flag set, or a cycle without the strobe, changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Command strobe, one cycle per command |
| req_rd | input | 1 | 1 = read command, 0 = write command |
| req_addr | input | 7 | Register address |
| req_wdata | input | 8 | Write data byte |
| pin_level | input | 10 | Asynchronous pin input levels, one per port |
| pull_n | output | 10 | Active-low pull-down enable, one per port |
| rd_data | output | 8 | Read data for `req_addr`, combinational |

## Verification
The bench builds the block with its default parameters: ten ports in groups of four. With these values the partial last group (ports 8 and 9) can be tested. So can a group address that reads back a port other than port 0, and a high pin-read byte that has unused bits which must stay zero. The two-stage synchroniser depth is also the default, so the bench probes the exact edge at which a pin change first appears.

// File: rtl/odx_pkg.sv
`timescale 1ns/1ps
package odx_pkg;

    localparam int unsigned AW = 7;
    localparam int unsigned DW = 8;

    localparam logic [AW-1:0] A_ALL    = 7'h0A;
    localparam logic [AW-1:0] A_GRP0   = 7'h0B;
    localparam logic [AW-1:0] A_PIN_LO = 7'h0E;
    localparam logic [AW-1:0] A_PIN_HI = 7'h0F;
    localparam logic [AW-1:0] A_RAM    = 7'h13;
    localparam logic [AW-1:0] A_NOP    = 7'h20;
    localparam logic [AW-1:0] A_RSVD   = 7'h7D;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_PORT,
        SRC_PIN_LO,
        SRC_PIN_HI,
        SRC_RAM
    } rd_src_e;

    typedef struct packed {
        logic          valid;
        logic          rd;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } req_t;

    function automatic int unsigned grp_count(input int unsigned ports,
                                              input int unsigned per_grp);
        return (ports + per_grp - 1) / per_grp;
    endfunction

endpackage

// File: rtl/odx_sync.sv
`timescale 1ns/1ps
module odx_sync #(
    parameter int unsigned W      = 10,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stg[s] <= '0;
            end else if (s == 0) begin
                stg[s] <= d;
            end else begin
                stg[s] <= stg[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/odx_reg.sv
`timescale 1ns/1ps
module odx_reg #(
    parameter int unsigned   W       = 8,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= RST_VAL;
        else if (we) q <= d;
    end
endmodule

// File: rtl/odx_decode.sv
`timescale 1ns/1ps
module odx_decode
    import odx_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 10,
    parameter int unsigned PER_GRP   = 4,
    parameter int unsigned IDX_W     = $clog2(NUM_PORTS)
) (
    input  req_t                  req,
    output logic [NUM_PORTS-1:0]  port_we,
    output logic                  ram_we,
    output rd_src_e               src,
    output logic [IDX_W-1:0]      idx
);
    localparam int unsigned   NUM_GRPS = grp_count(NUM_PORTS, PER_GRP);
    localparam logic [AW-1:0] PORT_LIM = AW'(NUM_PORTS);
    localparam logic [AW-1:0] GRP_LIM  = A_GRP0 + AW'(NUM_GRPS);

    logic [NUM_PORTS-1:0] hit;
    logic                 ram_hit;
    logic                 is_wr;

    always_comb begin
        hit     = '0;
        ram_hit = 1'b0;
        src     = SRC_NONE;
        idx     = '0;
        if (req.addr < PORT_LIM) begin
            src = SRC_PORT;
            idx = IDX_W'(req.addr);
            for (int p = 0; p < NUM_PORTS; p++)
                if (req.addr == AW'(p)) hit[p] = 1'b1;
        end else if (req.addr == A_ALL) begin
            src = SRC_PORT;
            hit = '1;
        end else if (req.addr >= A_GRP0 && req.addr < GRP_LIM) begin
            src = SRC_PORT;
            for (int g = 0; g < NUM_GRPS; g++) begin
                if (req.addr == A_GRP0 + AW'(g)) begin
                    idx = IDX_W'(g * PER_GRP);
                    for (int p = 0; p < NUM_PORTS; p++)
                        if (p / PER_GRP == g) hit[p] = 1'b1;
                end
            end
        end else if (req.addr == A_PIN_LO) begin
            src = SRC_PIN_LO;
        end else if (req.addr == A_PIN_HI) begin
            src = SRC_PIN_HI;
        end else if (req.addr == A_RAM) begin
            src     = SRC_RAM;
            ram_hit = 1'b1;
        end
    end

    assign is_wr   = req.valid && !req.rd;
    assign port_we = is_wr ? hit : '0;
    assign ram_we  = is_wr && ram_hit;
endmodule

// File: rtl/odx_bank.sv
`timescale 1ns/1ps
module odx_bank
    import odx_pkg::*;
#(
    parameter int unsigned NUM_PORTS   = 10,
    parameter int unsigned PER_GRP     = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_rd,
    input  logic [AW-1:0]        req_addr,
    input  logic [DW-1:0]        req_wdata,
    input  logic [NUM_PORTS-1:0] pin_level,
    output logic [NUM_PORTS-1:0] pull_n,
    output logic [DW-1:0]        rd_data
);
    localparam int unsigned IDX_W = $clog2(NUM_PORTS);

    req_t                 req;
    logic [NUM_PORTS-1:0] port_we;
    logic                 ram_we;
    rd_src_e              src;
    logic [IDX_W-1:0]     idx;
    logic [DW-1:0]        port_q [NUM_PORTS];
    logic [DW-1:0]        ram_q;
    logic [NUM_PORTS-1:0] pin_q;
    logic [2*DW-1:0]      pin_wide;

    assign req = '{valid: req_valid, rd: req_rd, addr: req_addr, data: req_wdata};

    odx_decode #(
        .NUM_PORTS (NUM_PORTS),
        .PER_GRP   (PER_GRP),
        .IDX_W     (IDX_W)
    ) u_dec (
        .req     (req),
        .port_we (port_we),
        .ram_we  (ram_we),
        .src     (src),
        .idx     (idx)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        odx_reg #(.W(DW), .RST_VAL({DW{1'b1}})) u_reg (
            .clk (clk),
            .rst (rst),
            .we  (port_we[p]),
            .d   (req.data),
            .q   (port_q[p])
        );
        assign pull_n[p] = port_q[p][0];
    end

    odx_reg #(.W(DW), .RST_VAL('0)) u_ram (
        .clk (clk),
        .rst (rst),
        .we  (ram_we),
        .d   (req.data),
        .q   (ram_q)
    );

    odx_sync #(.W(NUM_PORTS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_level),
        .q   (pin_q)
    );

    assign pin_wide = (2*DW)'(pin_q);

    always_comb begin
        unique case (src)
            SRC_PORT:   rd_data = port_q[idx];
            SRC_PIN_LO: rd_data = pin_wide[DW-1:0];
            SRC_PIN_HI: rd_data = pin_wide[2*DW-1:DW];
            SRC_RAM:    rd_data = ram_q;
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/odx_bank_chk.sv
`timescale 1ns/1ps
module odx_bank_chk
    import odx_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 10,
    parameter int unsigned PER_GRP   = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic                 req_rd,
    input logic [AW-1:0]        req_addr,
    input logic [DW-1:0]        req_wdata,
    input logic [NUM_PORTS-1:0] pull_n,
    input logic [DW-1:0]        rd_data
);
    logic wr;
    assign wr = req_valid && !req_rd;

    // R1
    reset_release_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pull_n == '1));

    // R11
    no_write_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(pull_n));

    // R4
    all_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && req_addr == A_ALL) |=> (pull_n == {NUM_PORTS{$past(req_wdata[0])}}));

    // R5
    first_grp_only_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && req_addr == A_GRP0) |=> $stable(pull_n[NUM_PORTS-1:PER_GRP]));

    // R7
    pin_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && (req_addr == A_PIN_LO || req_addr == A_PIN_HI)) |=> $stable(pull_n));

    // R10
    dead_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && (req_addr == A_NOP || req_addr == A_RSVD)) |=> $stable(pull_n));

    // R10
    dead_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (req_addr == A_NOP || req_addr == A_RSVD) |-> (rd_data == '0));
endmodule

bind odx_bank odx_bank_chk #(
    .NUM_PORTS (NUM_PORTS),
    .PER_GRP   (PER_GRP)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_rd    (req_rd),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .pull_n    (pull_n),
    .rd_data   (rd_data)
);

// File: tb/sim_odx_bank.sv
`timescale 1ns/1ps
module sim_odx_bank;
    logic       clk = 1'b0;
    logic       rst;
    logic       req_valid;
    logic       req_rd;
    logic [6:0] req_addr;
    logic [7:0] req_wdata;
    logic [9:0] pin_level;
    logic [9:0] pull_n;
    logic [7:0] rd_data;

    always #2 clk = ~clk;

    odx_bank u0 (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_rd    (req_rd),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .pin_level (pin_level),
        .pull_n    (pull_n),
        .rd_data   (rd_data)
    );

    typedef struct {
        bit          on_pull;
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t      sbq[$];
    int         n_chk  = 0;
    int         n_fail = 0;
    bit         done   = 0;
    logic [7:0] m_port [10];
    logic [7:0] m_ram;

    function automatic logic [9:0] m_pull();
        logic [9:0] r;
        for (int i = 0; i < 10; i++) r[i] = m_port[i][0];
        return r;
    endfunction

    function automatic logic [7:0] m_read(input logic [6:0] a);
        if (a < 7'd10)      return m_port[a];
        if (a == 7'h0A || a == 7'h0B) return m_port[0];
        if (a == 7'h0C)     return m_port[4];
        if (a == 7'h0D)     return m_port[8];
        if (a == 7'h13)     return m_ram;
        return 8'h00;
    endfunction

    // Monitor: one item per cycle, sampled 1 ns after the rising edge
    initial begin
        forever begin
            item_t       it;
            logic [15:0] act;
            @(posedge clk);
            #1;
            if (sbq.size() > 0) begin
                it  = sbq.pop_front();
                act = it.on_pull ? {6'b0, pull_n} : {8'b0, rd_data};
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [6:0] a, input logic [7:0] d, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_rd = 1'b0; req_addr = a; req_wdata = d;
        if (a < 7'd10) m_port[a] = d;
        else if (a == 7'h0A) for (int i = 0; i < 10; i++) m_port[i] = d;
        else if (a == 7'h0B) for (int i = 0; i < 4; i++)  m_port[i] = d;
        else if (a == 7'h0C) for (int i = 4; i < 8; i++)  m_port[i] = d;
        else if (a == 7'h0D) for (int i = 8; i < 10; i++) m_port[i] = d;
        else if (a == 7'h13) m_ram = d;
        sbq.push_back('{1'b1, {6'b0, m_pull()}, tag});
    endtask

    task automatic rd_exp(input logic [6:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_rd = 1'b1; req_addr = a; req_wdata = 8'h00;
        sbq.push_back('{1'b0, {8'b0, e}, tag});
    endtask

    task automatic rd(input logic [6:0] a, input string tag);
        rd_exp(a, m_read(a), tag);
    endtask

    task automatic chk_pull(input string tag);
        @(negedge clk);
        req_valid = 1'b0;
        sbq.push_back('{1'b1, {6'b0, m_pull()}, tag});
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_rd = 1'b0;
        req_addr = '0; req_wdata = '0; pin_level = 10'h155;
        for (int i = 0; i < 10; i++) m_port[i] = 8'hFF;
        m_ram = 8'h00;
        repeat (3) @(negedge clk);
        chk_pull("R1 pull during reset");
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        chk_pull("R1 pull after reset");
        for (int i = 0; i < 10; i++) rd(7'(i), "R1 port reset value");
        rd(7'h13, "R1 scratch reset value");

        // R2 R3 R11 individual writes, alternating bit 0
        for (int i = 0; i < 10; i++) wr(7'(i), 8'h40 + 8'(i * 17), "R11 R3 write visible next cycle");
        for (int i = 0; i < 10; i++) rd(7'(i), "R2 readback");
        chk_pull("R3 pull follows bit 0");

        // R5 R6 group writes
        wr(7'h0B, 8'h00, "R5 group 0 write");
        rd(7'h0B, "R6 group 0 reads port 0");
        rd(7'h04, "R5 port 4 untouched");
        wr(7'h0C, 8'h5A, "R5 group 1 write");
        rd(7'h0C, "R6 group 1 reads port 4");
        rd(7'h03, "R5 port 3 untouched");
        rd(7'h08, "R5 port 8 untouched");
        wr(7'h0D, 8'hC3, "R5 partial group 2 write");
        rd(7'h0D, "R6 group 2 reads port 8");
        rd(7'h09, "R5 port 9 in group 2");
        rd(7'h07, "R5 port 7 untouched");

        // R4 broadcast
        wr(7'h0A, 8'h00, "R4 broadcast low");
        wr(7'h0A, 8'h81, "R4 broadcast release");
        rd(7'h0A, "R6 broadcast address reads port 0");
        rd(7'h06, "R4 port 6 loaded");

        // R9 scratch
        wr(7'h13, 8'hA5, "R9 scratch write");
        rd(7'h13, "R9 scratch readback");

        // R10 R7 ignored writes
        wr(7'h20, 8'h00, "R10 no-op write");
        wr(7'h7D, 8'h00, "R10 reserved write");
        wr(7'h15, 8'h00, "R10 unmapped write");
        wr(7'h0E, 8'h00, "R7 pin-low write ignored");
        wr(7'h0F, 8'h00, "R7 pin-high write ignored");
        for (int i = 0; i < 10; i++) rd(7'(i), "R10 ports unchanged");
        rd(7'h13, "R10 scratch unchanged");
        rd(7'h20, "R10 no-op read zero");
        rd(7'h7D, "R10 reserved read zero");
        rd(7'h15, "R10 unmapped read zero");
        rd(7'h7F, "R10 top address read zero");

        // R7 R8 pin reads and synchroniser depth
        rd_exp(7'h0F, 8'h01, "R7 pins 9..8 initial");
        @(negedge clk);
        pin_level = 10'h2B5;
        req_valid = 1'b1; req_rd = 1'b1; req_addr = 7'h0E;
        sbq.push_back('{1'b0, 16'h0055, "R8 one edge not yet visible"});
        rd_exp(7'h0E, 8'hB5, "R8 visible after two edges");
        rd_exp(7'h0F, 8'h02, "R7 pins 9..8 packed");
        pin_level = 10'h000;
        repeat (3) rd_exp(7'h0E, 8'h00, "R7 pins low");

        // R11 read strobe and idle do not write
        wr(7'h05, 8'h00, "R11 port 5 low");
        rd_exp(7'h05, 8'h00, "R11 read strobe setup");
        @(negedge clk);
        req_valid = 1'b1; req_rd = 1'b1; req_addr = 7'h0A; req_wdata = 8'hFF;
        sbq.push_back('{1'b1, {6'b0, m_pull()}, "R11 read strobe no write"});
        @(negedge clk);
        req_valid = 1'b0; req_rd = 1'b0; req_addr = 7'h0A; req_wdata = 8'hFF;
        sbq.push_back('{1'b1, {6'b0, m_pull()}, "R11 idle no write"});
        rd(7'h05, "R11 port 5 kept");
        rd(7'h00, "R11 port 0 kept");

        @(negedge clk); req_valid = 1'b0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule